// File: doc/BRIEF.md
# Watchpoint Comparator Bank

This block watches two streams of processor activity, the instruction-fetch address and the data-bus transactions, through a small bank of independent comparators. Each comparator is given a mode, a reference address, an address mask size, a reference value with an operand size, and up to two links. When its condition holds for an access, it raises a one-cycle event. Debug logic that starts or stops trace capture, or counts down a trigger, consumes these events.

An address comparator can match the program counter or the address of a data access. It can restrict the data access to reads, to writes, or accept either. If the mask size is nonzero, the match covers an aligned range of addresses. A value comparator checks the data moved by a bus access at a chosen operand size. Its event can be limited to accesses whose address also hits one or two linked address comparators, so that the event means "this value was written to this location".

Each comparator is set through a single-entry configuration write port. A write takes effect for accesses presented in the cycle after the write edge. Each event is registered, so it appears exactly one cycle after the access that caused it.

Top module: `wp_bank`

## Requirements
- R1: While reset is asserted and after it is released, every event output and every configuration-error flag is low, and every comparator is in mode OFF (code 0).
- R2: In instruction mode (code 1), a comparator fires when `pc_valid_i` is high and the program counter equals the reference address outside the masked bits. A program counter presented with `pc_valid_i` low never fires.
- R3: A mask size of k makes the comparator ignore the k low-order address bits, so any address in the aligned 2^k range matches. Mask size 0 needs an exact match.
- R4: Data-address modes need `bus_valid_i` high and a matching `bus_addr_i`. Read/write mode (code 2) accepts any access, read mode (code 3) needs `bus_write_i` low, and write mode (code 4) needs `bus_write_i` high.
- R5: Data-address modes ignore `bus_data_i` and `bus_size_i` entirely.
- R6: Value modes compare only the low bits of `bus_data_i` at the configured size: code 0 uses bits 7:0, code 1 uses bits 15:0, code 2 uses the whole word. They fire only when `bus_size_i` equals the configured size. Size code 3 in a value mode is a configuration error.
- R7: Value modes follow the same direction rules as the address modes: read/write (code 5) accepts any access, read (code 6) needs a read, and write (code 7) needs a write. They do not use the reference address.
- R8: A value comparator with no link enabled fires on the value alone. With one or both links enabled, it fires only if at least one enabled linked comparator has a data-address hit on the same access.
- R9: An instruction-mode comparator whose reference address has bit 0 set raises its configuration-error flag and never fires.
- R10: Events are registered. A matching access in cycle t gives the event in cycle t+1 only, and consecutive matching accesses give consecutive event cycles.
- R11: A configuration write is captured on the clock edge. An access presented in the same cycle as the write still uses the old settings, and the next cycle uses the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_i | input | AW | Instruction-fetch address |
| pc_valid_i | input | 1 | Instruction address is valid this cycle |
| bus_addr_i | input | AW | Data access address |
| bus_data_i | input | DW | Data moved by the access |
| bus_size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_write_i | input | 1 | 1 for a write, 0 for a read |
| bus_valid_i | input | 1 | Data access is valid this cycle |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IW | Comparator selected by the write |
| cfg_mode_i | input | 3 | Mode code (0 off, 1..7 as in the requirements) |
| cfg_addr_i | input | AW | Reference address |
| cfg_mask_i | input | MW | Number of ignored low address bits |
| cfg_vsize_i | input | 2 | Value operand size code |
| cfg_value_i | input | DW | Reference value |
| cfg_link0_en_i | input | 1 | Enable first link |
| cfg_link0_i | input | IW | First linked comparator |
| cfg_link1_en_i | input | 1 | Enable second link |
| cfg_link1_i | input | IW | Second linked comparator |
| evt_o | output | N | Registered per-comparator event |
| cfg_err_o | output | N | Per-comparator configuration error |

## Verification
The assertions check several rules on every cycle. No event follows a cycle without a valid access. A comparator that is off, or in error, never fires. An instruction comparator stays silent without a valid program counter. A value comparator stays silent without a valid bus access. The bench scenarios are the only place to show what a match means. They cover the mask ranges, the direction and size rules, the independence of address modes from the data, link gating across comparators, the misalignment error, and the one-cycle timing of configuration writes.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [2:0] {
    WM_OFF   = 3'd0,
    WM_IADDR = 3'd1,
    WM_DRW   = 3'd2,
    WM_DRD   = 3'd3,
    WM_DWR   = 3'd4,
    WM_VRW   = 3'd5,
    WM_VRD   = 3'd6,
    WM_VWR   = 3'd7
  } wp_mode_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  function automatic logic is_value_mode(input wp_mode_e m);
    return (m == WM_VRW) || (m == WM_VRD) || (m == WM_VWR);
  endfunction

  function automatic logic is_daddr_mode(input wp_mode_e m);
    return (m == WM_DRW) || (m == WM_DRD) || (m == WM_DWR);
  endfunction
endpackage

// File: rtl/wp_cfg_regs.sv
module wp_cfg_regs
  import wp_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int MW = 5,
  parameter int IW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IW-1:0]   idx,
  input  logic [2:0]      mode_in,
  input  logic [AW-1:0]   addr_in,
  input  logic [MW-1:0]   mask_in,
  input  logic [1:0]      vsize_in,
  input  logic [DW-1:0]   value_in,
  input  logic            l0e_in,
  input  logic [IW-1:0]   l0_in,
  input  logic            l1e_in,
  input  logic [IW-1:0]   l1_in,
  output wp_mode_e        mode_q  [N],
  output logic [AW-1:0]   addr_q  [N],
  output logic [MW-1:0]   mask_q  [N],
  output logic [1:0]      vsize_q [N],
  output logic [DW-1:0]   value_q [N],
  output logic            l0e_q   [N],
  output logic [IW-1:0]   l0_q    [N],
  output logic            l1e_q   [N],
  output logic [IW-1:0]   l1_q    [N]
);
  logic [N-1:0] load;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      load[i] = we && (idx == IW'(i));
    end
  end

  generate
    for (genvar g = 0; g < N; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mode_q[g]  <= WM_OFF;
          addr_q[g]  <= '0;
          mask_q[g]  <= '0;
          vsize_q[g] <= '0;
          value_q[g] <= '0;
          l0e_q[g]   <= 1'b0;
          l0_q[g]    <= '0;
          l1e_q[g]   <= 1'b0;
          l1_q[g]    <= '0;
        end else if (load[g]) begin
          mode_q[g]  <= wp_mode_e'(mode_in);
          addr_q[g]  <= addr_in;
          mask_q[g]  <= mask_in;
          vsize_q[g] <= vsize_in;
          value_q[g] <= value_in;
          l0e_q[g]   <= l0e_in;
          l0_q[g]    <= l0_in;
          l1e_q[g]   <= l1e_in;
          l1_q[g]    <= l1_in;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/wp_cmp.sv
module wp_cmp
  import wp_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int MW = 5
) (
  input  wp_mode_e      mode,
  input  logic [AW-1:0] ref_addr,
  input  logic [MW-1:0] mask,
  input  logic [1:0]    vsize,
  input  logic [DW-1:0] ref_value,
  input  logic [AW-1:0] pc,
  input  logic          pc_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic [1:0]    bus_size,
  input  logic          bus_write,
  input  logic          bus_valid,
  output logic          ihit,
  output logic          ahit,
  output logic          vhit,
  output logic          err
);
  logic [AW-1:0] keep;
  logic [DW-1:0] vmask;
  logic          dir_ok;
  logic          val_mode;

  always_comb begin
    keep     = ~((AW'(1) << mask) - AW'(1));
    val_mode = is_value_mode(mode);
    err      = ((mode == WM_IADDR) && ref_addr[0]) ||
               (val_mode && (vsize == 2'd3));
    unique case (vsize)
      SZ_BYTE: vmask = DW'(8'hFF);
      SZ_HALF: vmask = DW'(16'hFFFF);
      default: vmask = '1;
    endcase
    unique case (mode)
      WM_DRD, WM_VRD: dir_ok = !bus_write;
      WM_DWR, WM_VWR: dir_ok = bus_write;
      default:        dir_ok = 1'b1;
    endcase
    ihit = (mode == WM_IADDR) && !err && pc_valid &&
           (((pc ^ ref_addr) & keep) == '0);
    ahit = is_daddr_mode(mode) && bus_valid && dir_ok &&
           (((bus_addr ^ ref_addr) & keep) == '0);
    vhit = val_mode && !err && bus_valid && dir_ok &&
           (bus_size == vsize) &&
           (((bus_data ^ ref_value) & vmask) == '0);
  end
endmodule

// File: rtl/wp_link.sv
module wp_link #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  ihit,
  input  logic [N-1:0]  ahit,
  input  logic [N-1:0]  vhit,
  input  logic          l0e [N],
  input  logic [IW-1:0] l0  [N],
  input  logic          l1e [N],
  input  logic [IW-1:0] l1  [N],
  output logic [N-1:0]  hit
);
  generate
    for (genvar g = 0; g < N; g++) begin : g_gate
      logic link_ok;
      always_comb begin
        link_ok = (!l0e[g] && !l1e[g]) ||
                  (l0e[g] && ahit[l0[g]]) ||
                  (l1e[g] && ahit[l1[g]]);
        hit[g]  = ihit[g] || ahit[g] || (vhit[g] && link_ok);
      end
    end
  endgenerate
endmodule

// File: rtl/wp_bank.sv
module wp_bank
  import wp_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int MW = $clog2(AW),
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] pc_i,
  input  logic          pc_valid_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_data_i,
  input  logic [1:0]    bus_size_i,
  input  logic          bus_write_i,
  input  logic          bus_valid_i,
  input  logic          cfg_we_i,
  input  logic [IW-1:0] cfg_idx_i,
  input  logic [2:0]    cfg_mode_i,
  input  logic [AW-1:0] cfg_addr_i,
  input  logic [MW-1:0] cfg_mask_i,
  input  logic [1:0]    cfg_vsize_i,
  input  logic [DW-1:0] cfg_value_i,
  input  logic          cfg_link0_en_i,
  input  logic [IW-1:0] cfg_link0_i,
  input  logic          cfg_link1_en_i,
  input  logic [IW-1:0] cfg_link1_i,
  output logic [N-1:0]  evt_o,
  output logic [N-1:0]  cfg_err_o
);
  wp_mode_e      cmp_mode  [N];
  logic [AW-1:0] cmp_addr  [N];
  logic [MW-1:0] cmp_mask  [N];
  logic [1:0]    cmp_vsize [N];
  logic [DW-1:0] cmp_value [N];
  logic          cmp_l0e   [N];
  logic [IW-1:0] cmp_l0    [N];
  logic          cmp_l1e   [N];
  logic [IW-1:0] cmp_l1    [N];

  logic [N-1:0] ihit, ahit, vhit, err, hit;
  logic [N-1:0] evt_d, evt_q;

  wp_cfg_regs #(.N(N), .AW(AW), .DW(DW), .MW(MW), .IW(IW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we_i), .idx(cfg_idx_i),
    .mode_in(cfg_mode_i), .addr_in(cfg_addr_i), .mask_in(cfg_mask_i),
    .vsize_in(cfg_vsize_i), .value_in(cfg_value_i),
    .l0e_in(cfg_link0_en_i), .l0_in(cfg_link0_i),
    .l1e_in(cfg_link1_en_i), .l1_in(cfg_link1_i),
    .mode_q(cmp_mode), .addr_q(cmp_addr), .mask_q(cmp_mask),
    .vsize_q(cmp_vsize), .value_q(cmp_value),
    .l0e_q(cmp_l0e), .l0_q(cmp_l0), .l1e_q(cmp_l1e), .l1_q(cmp_l1)
  );

  generate
    for (genvar g = 0; g < N; g++) begin : g_cmp
      wp_cmp #(.AW(AW), .DW(DW), .MW(MW)) u_cmp (
        .mode(cmp_mode[g]), .ref_addr(cmp_addr[g]), .mask(cmp_mask[g]),
        .vsize(cmp_vsize[g]), .ref_value(cmp_value[g]),
        .pc(pc_i), .pc_valid(pc_valid_i),
        .bus_addr(bus_addr_i), .bus_data(bus_data_i),
        .bus_size(bus_size_i), .bus_write(bus_write_i),
        .bus_valid(bus_valid_i),
        .ihit(ihit[g]), .ahit(ahit[g]), .vhit(vhit[g]), .err(err[g])
      );
    end
  endgenerate

  wp_link #(.N(N), .IW(IW)) u_link (
    .ihit(ihit), .ahit(ahit), .vhit(vhit),
    .l0e(cmp_l0e), .l0(cmp_l0), .l1e(cmp_l1e), .l1(cmp_l1),
    .hit(hit)
  );

  always_comb begin
    evt_d = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
    end else begin
      evt_q <= evt_d;
    end
  end

  assign evt_o     = evt_q;
  assign cfg_err_o = err;
endmodule

// File: rtl/wp_bank_chk.sv
module wp_bank_chk
  import wp_pkg::*;
#(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         pc_valid_i,
  input logic         bus_valid_i,
  input wp_mode_e     mode [N],
  input logic [N-1:0] evt_o,
  input logic [N-1:0] cfg_err_o
);
  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (evt_o == '0);
    end
  end

  // R10
  no_event_without_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(pc_valid_i) && !$past(bus_valid_i)) |-> (evt_o == '0));

  // R9
  err_never_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(cfg_err_o) & evt_o) == '0));

  generate
    for (genvar g = 0; g < N; g++) begin : g_chk
      // R1
      off_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode[g]) == WM_OFF) |-> !evt_o[g]);
      // R2
      iaddr_needs_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(mode[g]) == WM_IADDR) && !$past(pc_valid_i)) |-> !evt_o[g]);
      // R6
      value_needs_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_value_mode($past(mode[g])) && !$past(bus_valid_i)) |-> !evt_o[g]);
    end
  endgenerate
endmodule

bind wp_bank wp_bank_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .pc_valid_i(pc_valid_i),
  .bus_valid_i(bus_valid_i), .mode(cmp_mode),
  .evt_o(evt_o), .cfg_err_o(cfg_err_o)
);

// File: tb/tb_wp_bank.sv
module tb_wp_bank;
  localparam int N = 4, AW = 32, DW = 32, MW = 5, IW = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] pc_i;
  logic pc_valid_i;
  logic [AW-1:0] bus_addr_i;
  logic [DW-1:0] bus_data_i;
  logic [1:0] bus_size_i;
  logic bus_write_i, bus_valid_i;
  logic cfg_we_i;
  logic [IW-1:0] cfg_idx_i;
  logic [2:0] cfg_mode_i;
  logic [AW-1:0] cfg_addr_i;
  logic [MW-1:0] cfg_mask_i;
  logic [1:0] cfg_vsize_i;
  logic [DW-1:0] cfg_value_i;
  logic cfg_link0_en_i, cfg_link1_en_i;
  logic [IW-1:0] cfg_link0_i, cfg_link1_i;
  logic [N-1:0] evt_o, cfg_err_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  wp_bank #(.N(N), .AW(AW), .DW(DW), .MW(MW), .IW(IW)) dut (.*);

  task automatic check(input string req, input string what,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic cfg(input int idx, input int mode, input logic [AW-1:0] addr,
                     input int mask, input int vsz, input logic [DW-1:0] val,
                     input logic l0e, input int l0, input logic l1e, input int l1);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_idx_i = IW'(idx); cfg_mode_i = 3'(mode);
    cfg_addr_i = addr; cfg_mask_i = MW'(mask); cfg_vsize_i = 2'(vsz);
    cfg_value_i = val; cfg_link0_en_i = l0e; cfg_link0_i = IW'(l0);
    cfg_link1_en_i = l1e; cfg_link1_i = IW'(l1);
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic clear_all();
    for (int i = 0; i < N; i++) cfg(i, 0, '0, 0, 0, '0, 0, 0, 0, 0);
  endtask

  task automatic pc_access(input logic [AW-1:0] pc, input logic v,
                           output logic [N-1:0] ev);
    @(negedge clk);
    pc_i = pc; pc_valid_i = v;
    @(negedge clk);
    pc_valid_i = 1'b0;
    ev = evt_o;
  endtask

  task automatic bus_access(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input int sz, input logic wr,
                            output logic [N-1:0] ev);
    @(negedge clk);
    bus_addr_i = a; bus_data_i = d; bus_size_i = 2'(sz);
    bus_write_i = wr; bus_valid_i = 1'b1;
    @(negedge clk);
    bus_valid_i = 1'b0;
    ev = evt_o;
  endtask

  task automatic t_reset();
    check("R1", "events after reset", evt_o, '0);
    check("R1", "errors after reset", cfg_err_o, '0);
  endtask

  task automatic t_iaddr();
    logic [N-1:0] ev;
    clear_all();
    cfg(0, 1, 32'h100, 0, 0, '0, 0, 0, 0, 0);
    pc_access(32'h100, 1'b1, ev); check("R2", "pc exact", ev, 4'b0001);
    pc_access(32'h102, 1'b1, ev); check("R2", "pc other", ev, 4'b0000);
    pc_access(32'h100, 1'b0, ev); check("R2", "pc not valid", ev, 4'b0000);
  endtask

  task automatic t_mask();
    logic [N-1:0] ev;
    cfg(0, 1, 32'h1000, 4, 0, '0, 0, 0, 0, 0);
    pc_access(32'h100E, 1'b1, ev); check("R3", "inside range", ev, 4'b0001);
    pc_access(32'h1010, 1'b1, ev); check("R3", "outside range", ev, 4'b0000);
  endtask

  task automatic t_misalign();
    logic [N-1:0] ev;
    cfg(0, 1, 32'h101, 0, 0, '0, 0, 0, 0, 0);
    check("R9", "error flag", cfg_err_o, 4'b0001);
    pc_access(32'h101, 1'b1, ev); check("R9", "never fires", ev, 4'b0000);
    cfg(0, 0, '0, 0, 0, '0, 0, 0, 0, 0);
    check("R9", "error cleared", cfg_err_o, 4'b0000);
  endtask

  task automatic t_daddr();
    logic [N-1:0] ev;
    clear_all();
    cfg(1, 2, 32'h2000, 0, 0, '0, 0, 0, 0, 0);
    cfg(2, 3, 32'h2000, 0, 0, '0, 0, 0, 0, 0);
    cfg(3, 4, 32'h2000, 0, 0, '0, 0, 0, 0, 0);
    bus_access(32'h2000, 32'h0, 2, 1'b0, ev); check("R4", "read", ev, 4'b0110);
    bus_access(32'h2000, 32'h0, 2, 1'b1, ev); check("R4", "write", ev, 4'b1010);
    bus_access(32'h2004, 32'h0, 2, 1'b1, ev); check("R4", "miss", ev, 4'b0000);
    bus_access(32'h2000, 32'hDEADBEEF, 0, 1'b1, ev);
    check("R5", "data and size ignored", ev, 4'b1010);
  endtask

  task automatic t_value();
    logic [N-1:0] ev;
    clear_all();
    cfg(0, 7, '0, 0, 0, 32'hAB, 0, 0, 0, 0);
    bus_access(32'h3000, 32'h123456AB, 0, 1'b1, ev); check("R6", "byte low bits", ev, 4'b0001);
    bus_access(32'h3000, 32'h000000AB, 1, 1'b1, ev); check("R6", "size mismatch", ev, 4'b0000);
    cfg(0, 7, '0, 0, 1, 32'h00FF, 0, 0, 0, 0);
    bus_access(32'h3000, 32'hABCD00FF, 1, 1'b1, ev); check("R6", "half low bits", ev, 4'b0001);
    bus_access(32'h3000, 32'h000001FF, 1, 1'b1, ev); check("R6", "half differs", ev, 4'b0000);
    cfg(0, 7, '0, 0, 2, 32'h12345678, 0, 0, 0, 0);
    bus_access(32'h3000, 32'h12345678, 2, 1'b1, ev); check("R6", "word", ev, 4'b0001);
    bus_access(32'h3000, 32'h02345678, 2, 1'b1, ev); check("R6", "word top differs", ev, 4'b0000);
    cfg(0, 7, '0, 0, 3, 32'h0, 0, 0, 0, 0);
    check("R6", "size 3 error", cfg_err_o, 4'b0001);
    bus_access(32'h3000, 32'h0, 3, 1'b1, ev); check("R6", "size 3 silent", ev, 4'b0000);
  endtask

  task automatic t_vdir();
    logic [N-1:0] ev;
    clear_all();
    cfg(0, 6, '0, 0, 2, 32'h55, 0, 0, 0, 0);
    cfg(1, 5, '0, 0, 2, 32'h55, 0, 0, 0, 0);
    bus_access(32'h10, 32'h55, 2, 1'b0, ev); check("R7", "read", ev, 4'b0011);
    bus_access(32'h10, 32'h55, 2, 1'b1, ev); check("R7", "write", ev, 4'b0010);
  endtask

  task automatic t_link();
    logic [N-1:0] ev;
    clear_all();
    cfg(1, 4, 32'h4000, 0, 0, '0, 0, 0, 0, 0);
    cfg(2, 4, 32'h5000, 0, 0, '0, 0, 0, 0, 0);
    cfg(0, 7, '0, 0, 2, 32'hFF, 1, 1, 1, 2);
    bus_access(32'h4000, 32'hFF, 2, 1'b1, ev); check("R8", "link0 hit", ev, 4'b0011);
    bus_access(32'h5000, 32'hFF, 2, 1'b1, ev); check("R8", "link1 hit", ev, 4'b0101);
    bus_access(32'h6000, 32'hFF, 2, 1'b1, ev); check("R8", "no link hit", ev, 4'b0000);
    bus_access(32'h4000, 32'h07, 2, 1'b1, ev); check("R8", "value miss", ev, 4'b0010);
    cfg(0, 7, '0, 0, 2, 32'hFF, 1, 1, 0, 2);
    bus_access(32'h5000, 32'hFF, 2, 1'b1, ev); check("R8", "link1 disabled", ev, 4'b0100);
    cfg(0, 7, '0, 0, 2, 32'hFF, 0, 1, 0, 2);
    bus_access(32'h6000, 32'hFF, 2, 1'b1, ev); check("R8", "unlinked", ev, 4'b0001);
  endtask

  task automatic t_pulse();
    clear_all();
    cfg(0, 1, 32'h200, 0, 0, '0, 0, 0, 0, 0);
    @(negedge clk);
    pc_i = 32'h200; pc_valid_i = 1'b1;
    @(negedge clk);
    check("R10", "first cycle", evt_o, 4'b0001);
    @(negedge clk);
    pc_valid_i = 1'b0;
    check("R10", "second cycle", evt_o, 4'b0001);
    @(negedge clk);
    check("R10", "drops after", evt_o, 4'b0000);
  endtask

  task automatic t_cfgtime();
    clear_all();
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_idx_i = 2'd3; cfg_mode_i = 3'd1;
    cfg_addr_i = 32'h300; cfg_mask_i = '0; cfg_vsize_i = '0; cfg_value_i = '0;
    cfg_link0_en_i = 1'b0; cfg_link1_en_i = 1'b0;
    pc_i = 32'h300; pc_valid_i = 1'b1;
    @(negedge clk);
    cfg_we_i = 1'b0;
    check("R11", "same cycle old config", evt_o, 4'b0000);
    @(negedge clk);
    pc_valid_i = 1'b0;
    check("R11", "next cycle new config", evt_o, 4'b1000);
  endtask

  initial begin
    #4_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    pc_i = '0; pc_valid_i = 1'b0; bus_addr_i = '0; bus_data_i = '0;
    bus_size_i = '0; bus_write_i = 1'b0; bus_valid_i = 1'b0;
    cfg_we_i = 1'b0; cfg_idx_i = '0; cfg_mode_i = '0; cfg_addr_i = '0;
    cfg_mask_i = '0; cfg_vsize_i = '0; cfg_value_i = '0;
    cfg_link0_en_i = 1'b0; cfg_link0_i = '0; cfg_link1_en_i = 1'b0; cfg_link1_i = '0;
    repeat (3) @(negedge clk);
    check("R1", "events in reset", evt_o, '0);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_iaddr();
    t_mask();
    t_misalign();
    t_daddr();
    t_value();
    t_vdir();
    t_link();
    t_pulse();
    t_cfgtime();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule